// File: doc/BRIEF.md
# Register Rename Map Table

This block translates architectural register numbers into physical register numbers for an out-of-order core. It holds two complete translation memories. The speculative copy is written as instructions leave rename. The committed copy is written as instructions retire. A one-bit selector per architectural register says which copy holds the live translation for that register. Source-operand lookups come in on several parallel read ports. Each port answers one cycle after its request.

When a branch turns out to be mispredicted, the flush input clears every selector bit in a single cycle. All lookups then fall back to the committed copy. Recovery needs no snapshot, no saved copy and no walk through in-flight instructions. Register 0 is hard-wired: it always translates to physical 0 and is never remapped. The lookup, rename-write and commit-write interfaces carry a valid bit and no ready. The table accepts a request on every cycle, and no interface can apply back-pressure.

Top module: `rename_map_table`

## Requirements
- R1: After reset, a lookup of architectural register i returns physical register i for every i, and no response is marked valid until a lookup has been requested.
- R2: `rd_rsp_valid[k]` is high exactly in the cycle after the cycle in which `rd_req_valid[k]` was high.
- R3: An accepted rename write of register r (r ≠ 0, no flush in that cycle) makes every later lookup of r return the written physical number, until a later rename write of r or a flush.
- R4: A lookup of register r in the same cycle as an accepted rename write of r returns the newly written physical number (bypass).
- R5: A lookup of a register that has had no accepted rename write since reset or since the last flush returns the committed translation. A commit write becomes visible to lookups issued in the following cycle.
- R6: A lookup issued in any cycle after a flush returns the committed translation for every register, until that register is renamed again.
- R7: A rename write in the same cycle as a flush is discarded. It is not bypassed to lookups in that cycle and it leaves no trace in later lookups.
- R8: A lookup of register 0 always returns physical 0. Rename and commit writes to register 0 have no effect.
- R9: A commit write in the same cycle as a flush still takes effect, and lookups in the next cycle return the newly committed number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Misprediction recovery: clears all selector bits |
| rn_valid | input | 1 | Rename write request |
| rn_arch | input | AW | Architectural register being renamed |
| rn_phys | input | PW | New physical register for it |
| cm_valid | input | 1 | Commit write request |
| cm_arch | input | AW | Architectural register retiring |
| cm_phys | input | PW | Physical register it retires to |
| rd_req_valid | input | NUM_RD | Per-port lookup request |
| rd_req_arch | input | NUM_RD*AW | Per-port architectural register, port k at bits k*AW |
| rd_rsp_valid | output | NUM_RD | Per-port response valid, one cycle later |
| rd_rsp_phys | output | NUM_RD*PW | Per-port physical register, port k at bits k*PW |

## Verification
The hardest case to reach from the ports is a collision in one cycle: a lookup, a rename write and a flush all hit the same register, with a commit write to that register close by. Uniform random register numbers rarely collide. The stimulus therefore draws most register numbers from a small pool of six, including register 0, and flushes often enough that many renames sit close to a recovery. Directed cycles then force the flush-with-rename and flush-with-commit collisions explicitly.

// File: rtl/rmt_pkg.sv
`timescale 1ns/1ps
package rmt_pkg;

  // Which of the two translation copies a selector bit points at.
  typedef enum logic {
    MAP_COMMITTED   = 1'b0,
    MAP_SPECULATIVE = 1'b1
  } map_sel_e;

  // Width needed to index n entries, never below one bit.
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/rmt_map_mem.sv
`timescale 1ns/1ps
// One translation copy: flop storage, one write port, N_RD asynchronous reads.
module rmt_map_mem #(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned IW    = 5,
  parameter int unsigned DW    = 6,
  parameter int unsigned N_RD  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [N_RD*IW-1:0] rd_idx,
  output logic [N_RD*DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [N_ENT];

  // Each entry resets to the identity translation.
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_q[e] <= DW'(e);
      end else if (wr_en && (wr_idx == IW'(e))) begin
        mem_q[e] <= wr_data;
      end
    end
  end

  for (genvar k = 0; k < N_RD; k++) begin : g_rd
    assign rd_data[k*DW +: DW] = mem_q[rd_idx[k*IW +: IW]];
  end

endmodule

// File: rtl/rmt_loc_bits.sv
`timescale 1ns/1ps
// Per-register selector flops; all clear together on flush.
module rmt_loc_bits #(
  parameter int unsigned N_ENT = 32,
  parameter int unsigned IW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             set_en,
  input  logic [IW-1:0]    set_idx,
  output logic [N_ENT-1:0] loc_q
);

  import rmt_pkg::*;

  for (genvar e = 0; e < N_ENT; e++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        loc_q[e] <= MAP_COMMITTED;
      end else if (set_en && (set_idx == IW'(e))) begin
        loc_q[e] <= MAP_SPECULATIVE;
      end
    end
  end

endmodule

// File: rtl/rmt_read_port.sv
`timescale 1ns/1ps
// One lookup port: copy select, same-cycle rename bypass, register 0, output flop.
module rmt_read_port #(
  parameter int unsigned AW = 5,
  parameter int unsigned PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_arch,
  input  logic          loc_bit,
  input  logic [PW-1:0] spec_phys,
  input  logic [PW-1:0] com_phys,
  input  logic          byp_en,
  input  logic [AW-1:0] byp_arch,
  input  logic [PW-1:0] byp_phys,
  output logic          rsp_valid,
  output logic [PW-1:0] rsp_phys
);

  import rmt_pkg::*;

  logic [PW-1:0] sel_phys;
  logic          byp_hit;

  assign byp_hit = byp_en && (byp_arch == req_arch);

  always_comb begin
    if (req_arch == '0) begin
      sel_phys = '0;
    end else if (byp_hit) begin
      sel_phys = byp_phys;
    end else if (map_sel_e'(loc_bit) == MAP_SPECULATIVE) begin
      sel_phys = spec_phys;
    end else begin
      sel_phys = com_phys;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_phys  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_phys <= sel_phys;
      end
    end
  end

endmodule

// File: rtl/rename_map_table.sv
`timescale 1ns/1ps
module rename_map_table #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  parameter int unsigned NUM_RD   = 4,
  localparam int unsigned AW = rmt_pkg::idx_width(NUM_ARCH),
  localparam int unsigned PW = rmt_pkg::idx_width(NUM_PHYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 rn_valid,
  input  logic [AW-1:0]        rn_arch,
  input  logic [PW-1:0]        rn_phys,
  input  logic                 cm_valid,
  input  logic [AW-1:0]        cm_arch,
  input  logic [PW-1:0]        cm_phys,
  input  logic [NUM_RD-1:0]    rd_req_valid,
  input  logic [NUM_RD*AW-1:0] rd_req_arch,
  output logic [NUM_RD-1:0]    rd_rsp_valid,
  output logic [NUM_RD*PW-1:0] rd_rsp_phys
);

  // Rename writes are dropped on flush and for register 0; commit writes only for register 0.
  logic rn_take;
  logic cm_take;
  assign rn_take = rn_valid && !flush && (rn_arch != '0);
  assign cm_take = cm_valid && (cm_arch != '0);

  logic [NUM_RD*PW-1:0] spec_rd;
  logic [NUM_RD*PW-1:0] com_rd;
  logic [NUM_ARCH-1:0]  loc_sel;

  rmt_map_mem #(
    .N_ENT(NUM_ARCH), .IW(AW), .DW(PW), .N_RD(NUM_RD)
  ) u_spec_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (rn_take),
    .wr_idx (rn_arch),
    .wr_data(rn_phys),
    .rd_idx (rd_req_arch),
    .rd_data(spec_rd)
  );

  rmt_map_mem #(
    .N_ENT(NUM_ARCH), .IW(AW), .DW(PW), .N_RD(NUM_RD)
  ) u_com_map (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cm_take),
    .wr_idx (cm_arch),
    .wr_data(cm_phys),
    .rd_idx (rd_req_arch),
    .rd_data(com_rd)
  );

  rmt_loc_bits #(
    .N_ENT(NUM_ARCH), .IW(AW)
  ) u_loc (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .set_en (rn_take),
    .set_idx(rn_arch),
    .loc_q  (loc_sel)
  );

  for (genvar k = 0; k < NUM_RD; k++) begin : g_port
    logic [AW-1:0] port_arch;
    assign port_arch = rd_req_arch[k*AW +: AW];

    rmt_read_port #(
      .AW(AW), .PW(PW)
    ) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(rd_req_valid[k]),
      .req_arch (port_arch),
      .loc_bit  (loc_sel[port_arch]),
      .spec_phys(spec_rd[k*PW +: PW]),
      .com_phys (com_rd[k*PW +: PW]),
      .byp_en   (rn_take),
      .byp_arch (rn_arch),
      .byp_phys (rn_phys),
      .rsp_valid(rd_rsp_valid[k]),
      .rsp_phys (rd_rsp_phys[k*PW +: PW])
    );
  end

endmodule

// File: rtl/rmt_checker.sv
`timescale 1ns/1ps
module rmt_checker #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_RD   = 4,
  parameter int unsigned AW       = 5,
  parameter int unsigned PW       = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flush,
  input logic                 rn_valid,
  input logic [AW-1:0]        rn_arch,
  input logic [PW-1:0]        rn_phys,
  input logic [NUM_RD-1:0]    rd_req_valid,
  input logic [NUM_RD*AW-1:0] rd_req_arch,
  input logic [NUM_RD-1:0]    rd_rsp_valid,
  input logic [NUM_RD*PW-1:0] rd_rsp_phys,
  input logic [NUM_ARCH-1:0]  loc_sel
);

  // High once at least one clock has passed out of reset, so $past is meaningful.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(flush)) |-> (loc_sel == '0));

  assert_flush_drops_rename_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(flush && rn_valid)) |-> !loc_sel[$past(rn_arch)]);

  assert_rename_selects_spec_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(rn_valid && !flush && (rn_arch != '0))) |-> loc_sel[$past(rn_arch)]);

  assert_zero_never_spec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !loc_sel[0]);

  for (genvar k = 0; k < NUM_RD; k++) begin : g_chk
    assert_rsp_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (rd_rsp_valid[k] == $past(rd_req_valid[k])));

    assert_zero_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_req_valid[k] && (rd_req_arch[k*AW +: AW] == '0)))
      |-> (rd_rsp_phys[k*PW +: PW] == '0));

    assert_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(rd_req_valid[k] && rn_valid && !flush && (rn_arch != '0)
                        && (rd_req_arch[k*AW +: AW] == rn_arch)))
      |-> (rd_rsp_phys[k*PW +: PW] == $past(rn_phys)));
  end

endmodule

bind rename_map_table rmt_checker #(
  .NUM_ARCH(NUM_ARCH), .NUM_RD(NUM_RD), .AW(AW), .PW(PW)
) u_rmt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .rn_valid    (rn_valid),
  .rn_arch     (rn_arch),
  .rn_phys     (rn_phys),
  .rd_req_valid(rd_req_valid),
  .rd_req_arch (rd_req_arch),
  .rd_rsp_valid(rd_rsp_valid),
  .rd_rsp_phys (rd_rsp_phys),
  .loc_sel     (loc_sel)
);

// File: tb/rename_map_table_bench.sv
`timescale 1ns/1ps
module rename_map_table_bench;

  localparam int unsigned NUM_ARCH = 32;
  localparam int unsigned NUM_PHYS = 64;
  localparam int unsigned NUM_RD   = 4;
  localparam int unsigned AW = 5;
  localparam int unsigned PW = 6;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic                 flush;
  logic                 rn_valid;
  logic [AW-1:0]        rn_arch;
  logic [PW-1:0]        rn_phys;
  logic                 cm_valid;
  logic [AW-1:0]        cm_arch;
  logic [PW-1:0]        cm_phys;
  logic [NUM_RD-1:0]    rd_req_valid;
  logic [NUM_RD*AW-1:0] rd_req_arch;
  logic [NUM_RD-1:0]    rd_rsp_valid;
  logic [NUM_RD*PW-1:0] rd_rsp_phys;

  always #2 clk = ~clk;

  rename_map_table #(
    .NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS), .NUM_RD(NUM_RD)
  ) u_rename_map_table (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .rn_valid(rn_valid), .rn_arch(rn_arch), .rn_phys(rn_phys),
    .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_phys(cm_phys),
    .rd_req_valid(rd_req_valid), .rd_req_arch(rd_req_arch),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_phys(rd_rsp_phys)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Reference state.
  logic [PW-1:0] m_spec [NUM_ARCH];
  logic [PW-1:0] m_com  [NUM_ARCH];
  logic          m_loc  [NUM_ARCH];
  logic          flush_prev;
  string         tag_force;

  task automatic model_reset();
    for (int i = 0; i < NUM_ARCH; i++) begin
      m_spec[i] = PW'(i);
      m_com[i]  = PW'(i);
      m_loc[i]  = 1'b0;
    end
    flush_prev = 1'b0;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive_idle();
    flush = 0; rn_valid = 0; rn_arch = '0; rn_phys = '0;
    cm_valid = 0; cm_arch = '0; cm_phys = '0;
    rd_req_valid = '0; rd_req_arch = '0;
  endtask

  // Predict outputs from the current inputs, advance the model, clock once, compare.
  task automatic step();
    logic [PW-1:0] exp_p [NUM_RD];
    string         tag   [NUM_RD];
    logic          exp_v [NUM_RD];
    for (int k = 0; k < NUM_RD; k++) begin
      int a;
      a = int'(rd_req_arch[k*AW +: AW]);
      exp_v[k] = rd_req_valid[k];
      if (a == 0) begin
        exp_p[k] = '0; tag[k] = "R8";
      end else if (rn_valid && !flush && int'(rn_arch) == a) begin
        exp_p[k] = rn_phys; tag[k] = "R4";
      end else if (m_loc[a]) begin
        exp_p[k] = m_spec[a]; tag[k] = "R3";
      end else begin
        exp_p[k] = m_com[a]; tag[k] = flush_prev ? "R6" : "R5";
      end
      if (tag_force != "") tag[k] = tag_force;
    end
    if (flush) begin
      for (int i = 0; i < NUM_ARCH; i++) m_loc[i] = 1'b0;
    end else if (rn_valid && rn_arch != '0) begin
      m_spec[rn_arch] = rn_phys;
      m_loc[rn_arch]  = 1'b1;
    end
    if (cm_valid && cm_arch != '0) m_com[cm_arch] = cm_phys;
    flush_prev = flush;
    @(posedge clk);
    #1;
    for (int k = 0; k < NUM_RD; k++) begin
      check("R2 valid", int'(rd_rsp_valid[k]), int'(exp_v[k]));
      if (exp_v[k]) check(tag[k], int'(rd_rsp_phys[k*PW +: PW]), int'(exp_p[k]));
    end
  endtask

  function automatic logic [AW-1:0] pick_arch();
    if (($urandom % 4) == 0) return AW'($urandom % NUM_ARCH);
    return AW'($urandom % 6);
  endfunction

  task automatic read_all(input logic [AW-1:0] a);
    for (int k = 0; k < NUM_RD; k++) begin
      rd_req_valid[k] = 1'b1;
      rd_req_arch[k*AW +: AW] = a;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1D5EED));
    tag_force = "";
    drive_idle();
    rst_n = 1'b0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R1: nothing valid straight out of reset.
    check("R1 idle valid", int'(rd_rsp_valid), 0);

    // R1: identity translation for every register.
    tag_force = "R1";
    for (int b = 0; b < NUM_ARCH; b += NUM_RD) begin
      for (int k = 0; k < NUM_RD; k++) begin
        rd_req_valid[k] = 1'b1;
        rd_req_arch[k*AW +: AW] = AW'(b + k);
      end
      step();
    end
    drive_idle();
    tag_force = "";

    // R8: writes to register 0 ignored.
    rn_valid = 1; rn_arch = '0; rn_phys = 6'd40;
    cm_valid = 1; cm_arch = '0; cm_phys = 6'd41;
    read_all('0);
    step();
    drive_idle(); read_all('0); step();

    // R3 + R4: rename 5 -> 33 with a same-cycle read, then read later.
    drive_idle(); rn_valid = 1; rn_arch = 5'd5; rn_phys = 6'd33; read_all(5'd5); step();
    drive_idle(); read_all(5'd5); step();

    // R5: commit is hidden while speculative, visible after flush (R6).
    drive_idle(); cm_valid = 1; cm_arch = 5'd5; cm_phys = 6'd50; step();
    drive_idle(); read_all(5'd5); step();
    drive_idle(); flush = 1; step();
    drive_idle(); read_all(5'd5); step();

    // R7: rename with flush in the same cycle, same-cycle and later reads.
    drive_idle(); rn_valid = 1; rn_arch = 5'd7; rn_phys = 6'd44; step();
    tag_force = "R7";
    drive_idle(); flush = 1; rn_valid = 1; rn_arch = 5'd7; rn_phys = 6'd45;
    read_all(5'd7); step();
    drive_idle(); read_all(5'd7); step();

    // R9: commit with flush in the same cycle.
    tag_force = "R9";
    drive_idle(); rn_valid = 1; rn_arch = 5'd9; rn_phys = 6'd20; step();
    drive_idle(); flush = 1; cm_valid = 1; cm_arch = 5'd9; cm_phys = 6'd61; step();
    drive_idle(); read_all(5'd9); step();
    tag_force = "";

    // Constrained random traffic.
    for (int n = 0; n < 4000; n++) begin
      flush    = (($urandom % 16) == 0);
      rn_valid = (($urandom % 4) != 0);
      rn_arch  = pick_arch();
      rn_phys  = PW'($urandom % NUM_PHYS);
      cm_valid = (($urandom % 3) != 0);
      cm_arch  = pick_arch();
      cm_phys  = PW'($urandom % NUM_PHYS);
      for (int k = 0; k < NUM_RD; k++) begin
        rd_req_valid[k] = (($urandom % 5) != 0);
        rd_req_arch[k*AW +: AW] = pick_arch();
      end
      step();
    end
    drive_idle();
    step();

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule